// File: doc/BRIEF.md
# Trap Dispatch and Handler Vector Unit

When a trap is raised, this unit picks the way it is handled and works out where the handler starts. It looks at the current trap level, the RED and hyperprivileged bits of the hypervisor state word, the privileged bit of the processor state word, the trap type, and the two base registers (privileged table base and hyperprivileged table base). From these it chooses one of four paths: RED, hyperprivileged, privileged or error. It also gives the trap type to record, the trap level that results and three consecutive fetch addresses: handler PC, next PC and the one after that.

A control module works out the privilege level and the path. It also chooses the trap type that indexes the vector table. That type is the real one in most cases, a fixed code for RED entry, or the guest-watchdog code when a guest has run out of privileged trap levels. A datapath module forms the address from the chosen base and registers every result. The results appear one cycle after the request, with a one-cycle valid pulse. The unit also drives constant power-on values for the trap level, global level, state words and tick counter, for the reset logic elsewhere to load.

Top module: `trap_dispatch`

## Requirements
- R1: Power-on values are constant. porTl is MAX_TL (6) and porGl is MAX_GL (3). porPstate is 13'h014, which sets only bit 4 (FPU enable) and bit 2 (privileged). porHpstate is 11'h024, which sets only bit 5 (RED) and bit 2 (hyperprivileged), so bit 10 (break enable) and bit 0 (level-zero trap) are clear. porTick is 64'h8000_0000_0000_0000. While in reset and after it, dispValid is 0 and every registered output is 0.
- R2: dispValid is 1 in exactly the cycle after a cycle with trapReq high. If trapReq is low, all other registered outputs keep their values.
- R3: When hpstateRed is 1, or curTl equals MAX_TL-1, the path is RED (code 2) and this rule comes before all others. The handler PC is 0xFF_F000_0000 OR ((5<<5) & 0xFF), which is 0xFF_F000_00A0.
- R4: When R3 does not apply and curTl is MAX_TL or more, the path is error (code 3). All three addresses are 0 and vecTl equals curTl.
- R5: Otherwise, when curTl is greater than MAX_PTL (2) and hpstateHpriv is 0, the next level is privileged and the path is hyperprivileged (code 1). The vector uses the guest-watchdog type 2, so the PC is (htba with bits 13:0 cleared) OR 0x40.
- R6: Otherwise, when hpstateHpriv is 1, or the trap type is 384 or more, the path is hyperprivileged (code 1). The PC is (htba with bits 13:0 cleared) OR (trapType<<5).
- R7: Otherwise the path is privileged (code 0). The PC is (tba with bits 14:0 cleared) OR (trapType<<5), and bit 14 is set when the new trap level curTl+1 is greater than 1. Whether pstatePriv is 0 or 1 makes no difference to the result.
- R8: On every path except error, handlerNpc is handlerPc+4 and handlerNnpc is handlerPc+8.
- R9: recTt is the trapType given with the request on every path. vecTl is curTl+1 on every path except error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapReq | input | 1 | A trap is raised in this cycle |
| trapType | input | 9 | Trap type of the request |
| curTl | input | 3 | Current trap level |
| hpstateRed | input | 1 | RED state bit |
| hpstateHpriv | input | 1 | Hyperprivileged bit |
| pstatePriv | input | 1 | Privileged bit |
| tba | input | 64 | Privileged trap table base |
| htba | input | 64 | Hyperprivileged trap table base |
| dispValid | output | 1 | One-cycle pulse, results are valid |
| dispPath | output | 2 | 0 privileged, 1 hyperprivileged, 2 RED, 3 error |
| recTt | output | 9 | Trap type to record |
| vecTl | output | 3 | Resulting trap level |
| handlerPc | output | 64 | Handler address |
| handlerNpc | output | 64 | Handler PC + 4 |
| handlerNnpc | output | 64 | Handler PC + 8 |
| porTl | output | 3 | Power-on trap level |
| porGl | output | 2 | Power-on global level |
| porPstate | output | 13 | Power-on processor state |
| porHpstate | output | 11 | Power-on hypervisor state |
| porTick | output | 64 | Power-on tick value |

## Verification
The checker looks at every cycle. It covers the valid pulse that follows each request and the holding of results when there is no request. It also checks that RED wins over everything else, that the error path is taken at full trap level, that a hyperprivileged requester always takes the hyperprivileged path, and that the three addresses are in sequence and aligned. Some cases can only be shown by the bench scenarios: the exact vector address for each base, the trap-level bit of the privileged vector, the trap type 383/384 boundary, the MAX_PTL boundary for the guest-watchdog path, and the power-on constants.

// File: rtl/trap_dispatch_pkg.sv
package trap_dispatch_pkg;

  localparam int TT_W = 9;

  typedef enum logic [1:0] {
    PATH_PRIV  = 2'd0,
    PATH_HYPER = 2'd1,
    PATH_RED   = 2'd2,
    PATH_ERROR = 2'd3
  } trapPath_e;

  typedef enum logic [1:0] {
    LVL_USER  = 2'd0,
    LVL_PRIV  = 2'd1,
    LVL_HYPER = 2'd2
  } privLevel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             capture;
    trapPath_e        path;
    logic [TT_W-1:0]  vecTt;
    logic             tlHighBit;
  } dispStrobe_t;

  localparam logic [TT_W-1:0] TT_RED_ENTRY  = TT_W'(5);
  localparam logic [TT_W-1:0] TT_GUEST_WDOG = TT_W'(2);
  localparam logic [TT_W-1:0] TT_HYPER_MIN  = TT_W'(384);

endpackage

// File: rtl/trap_dispatch_ctrl.sv
module trap_dispatch_ctrl
  import trap_dispatch_pkg::*;
#(
  parameter int TL_W    = 3,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2
) (
  input  logic             trapReq,
  input  logic [TT_W-1:0]  trapType,
  input  logic [TL_W-1:0]  curTl,
  input  logic             hpstateRed,
  input  logic             hpstateHpriv,
  input  logic             pstatePriv,
  output dispStrobe_t      strobe
);

  localparam logic [TL_W-1:0] TL_RED_AT = TL_W'(MAX_TL - 1);
  localparam logic [TL_W-1:0] TL_ERR_AT = TL_W'(MAX_TL);
  localparam logic [TL_W-1:0] TL_PRIV_LIMIT = TL_W'(MAX_PTL);

  privLevel_e curLevel;
  privLevel_e nextLevel;

  always_comb begin
    if (hpstateHpriv)    curLevel = LVL_HYPER;
    else if (pstatePriv) curLevel = LVL_PRIV;
    else                 curLevel = LVL_USER;
    // traps never lower the level; user and privileged both land in privileged
    nextLevel = (curLevel == LVL_HYPER) ? LVL_HYPER : LVL_PRIV;
  end

  always_comb begin
    strobe.capture   = trapReq;
    strobe.path      = PATH_PRIV;
    strobe.vecTt     = trapType;
    strobe.tlHighBit = (curTl != '0);
    if (hpstateRed || curTl == TL_RED_AT) begin
      strobe.path  = PATH_RED;
      strobe.vecTt = TT_RED_ENTRY;
    end else if (curTl >= TL_ERR_AT) begin
      strobe.path  = PATH_ERROR;
    end else if (curTl > TL_PRIV_LIMIT && nextLevel == LVL_PRIV) begin
      strobe.path  = PATH_HYPER;
      strobe.vecTt = TT_GUEST_WDOG;
    end else if (nextLevel == LVL_HYPER || trapType >= TT_HYPER_MIN) begin
      strobe.path  = PATH_HYPER;
    end
  end

endmodule

// File: rtl/trap_dispatch_dp.sv
module trap_dispatch_dp
  import trap_dispatch_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int TL_W       = 3,
  parameter int INST_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  dispStrobe_t       strobe,
  input  logic [TT_W-1:0]   trapType,
  input  logic [TL_W-1:0]   curTl,
  input  logic [ADDR_W-1:0] tba,
  input  logic [ADDR_W-1:0] htba,
  output logic              dispValid,
  output trapPath_e         dispPath,
  output logic [TT_W-1:0]   recTt,
  output logic [TL_W-1:0]   vecTl,
  output logic [ADDR_W-1:0] handlerPc,
  output logic [ADDR_W-1:0] handlerNpc,
  output logic [ADDR_W-1:0] handlerNnpc
);

  localparam int SLOT_SHIFT = 5;
  localparam int HYP_LOW    = TT_W + SLOT_SHIFT;   // 14
  localparam int PRIV_LOW   = HYP_LOW + 1;         // 15
  localparam int RED_LOW    = 8;
  localparam logic [ADDR_W-1:0] RED_BASE = ADDR_W'(40'hFF_F000_0000);
  localparam logic [ADDR_W-1:0] STEP1 = ADDR_W'(INST_BYTES);
  localparam logic [ADDR_W-1:0] STEP2 = ADDR_W'(2 * INST_BYTES);

  logic [HYP_LOW-1:0] slotOffset;
  logic [ADDR_W-1:0]  vecPc;
  logic [ADDR_W-1:0]  vecNpc;
  logic [ADDR_W-1:0]  vecNnpc;
  logic [TL_W-1:0]    nextTl;

  assign slotOffset = {strobe.vecTt, {SLOT_SHIFT{1'b0}}};

  always_comb begin
    unique case (strobe.path)
      PATH_RED:   vecPc = RED_BASE | ADDR_W'(slotOffset[RED_LOW-1:0]);
      PATH_HYPER: vecPc = {htba[ADDR_W-1:HYP_LOW], slotOffset};
      PATH_PRIV:  vecPc = {tba[ADDR_W-1:PRIV_LOW], strobe.tlHighBit, slotOffset};
      default:    vecPc = '0;
    endcase
  end

  always_comb begin
    if (strobe.path == PATH_ERROR) begin
      vecNpc  = '0;
      vecNnpc = '0;
      nextTl  = curTl;
    end else begin
      vecNpc  = vecPc + STEP1;
      vecNnpc = vecPc + STEP2;
      nextTl  = curTl + TL_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dispValid   <= 1'b0;
      dispPath    <= PATH_PRIV;
      recTt       <= '0;
      vecTl       <= '0;
      handlerPc   <= '0;
      handlerNpc  <= '0;
      handlerNnpc <= '0;
    end else begin
      dispValid <= strobe.capture;
      if (strobe.capture) begin
        dispPath    <= strobe.path;
        recTt       <= trapType;
        vecTl       <= nextTl;
        handlerPc   <= vecPc;
        handlerNpc  <= vecNpc;
        handlerNnpc <= vecNnpc;
      end
    end
  end

endmodule

// File: rtl/trap_dispatch.sv
module trap_dispatch
  import trap_dispatch_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int TL_W    = 3,
  parameter int GL_W    = 2,
  parameter int MAX_TL  = 6,
  parameter int MAX_PTL = 2,
  parameter int MAX_GL  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapReq,
  input  logic [TT_W-1:0]   trapType,
  input  logic [TL_W-1:0]   curTl,
  input  logic              hpstateRed,
  input  logic              hpstateHpriv,
  input  logic              pstatePriv,
  input  logic [ADDR_W-1:0] tba,
  input  logic [ADDR_W-1:0] htba,
  output logic              dispValid,
  output logic [1:0]        dispPath,
  output logic [TT_W-1:0]   recTt,
  output logic [TL_W-1:0]   vecTl,
  output logic [ADDR_W-1:0] handlerPc,
  output logic [ADDR_W-1:0] handlerNpc,
  output logic [ADDR_W-1:0] handlerNnpc,
  output logic [TL_W-1:0]   porTl,
  output logic [GL_W-1:0]   porGl,
  output logic [12:0]       porPstate,
  output logic [10:0]       porHpstate,
  output logic [63:0]       porTick
);

  localparam int PS_PEF   = 4;
  localparam int PS_PRIV  = 2;
  localparam int HPS_RED  = 5;
  localparam int HPS_HPRIV = 2;

  dispStrobe_t strobe;
  trapPath_e   pathQ;

  trap_dispatch_ctrl #(
    .TL_W(TL_W), .MAX_TL(MAX_TL), .MAX_PTL(MAX_PTL)
  ) u_ctrl (
    .trapReq(trapReq), .trapType(trapType), .curTl(curTl),
    .hpstateRed(hpstateRed), .hpstateHpriv(hpstateHpriv),
    .pstatePriv(pstatePriv), .strobe(strobe)
  );

  trap_dispatch_dp #(
    .ADDR_W(ADDR_W), .TL_W(TL_W), .INST_BYTES(4)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .trapType(trapType),
    .curTl(curTl), .tba(tba), .htba(htba),
    .dispValid(dispValid), .dispPath(pathQ), .recTt(recTt),
    .vecTl(vecTl), .handlerPc(handlerPc), .handlerNpc(handlerNpc),
    .handlerNnpc(handlerNnpc)
  );

  assign dispPath   = pathQ;
  assign porTl      = TL_W'(MAX_TL);
  assign porGl      = GL_W'(MAX_GL);
  assign porPstate  = 13'((1 << PS_PEF) | (1 << PS_PRIV));
  assign porHpstate = 11'((1 << HPS_RED) | (1 << HPS_HPRIV));
  assign porTick    = 64'h1 << 63;

endmodule

// File: rtl/trap_dispatch_chk.sv
module trap_dispatch_chk
  import trap_dispatch_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int TL_W   = 3,
  parameter int MAX_TL = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              trapReq,
  input logic [TT_W-1:0]   trapType,
  input logic [TL_W-1:0]   curTl,
  input logic              hpstateRed,
  input logic              hpstateHpriv,
  input logic              dispValid,
  input logic [1:0]        dispPath,
  input logic [TT_W-1:0]   recTt,
  input logic [ADDR_W-1:0] handlerPc,
  input logic [ADDR_W-1:0] handlerNpc,
  input logic [ADDR_W-1:0] handlerNnpc
);

  a_r2_valid_after_req: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> dispValid);

  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |=> !dispValid);

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |=> ($stable(handlerPc) && $stable(dispPath) && $stable(recTt)));

  a_r3_red_wins: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && hpstateRed) |=> (dispPath == 2'd2 && handlerPc == ADDR_W'(40'hFF_F000_00A0)));

  a_r4_error_at_max: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && !hpstateRed && curTl >= TL_W'(MAX_TL)) |=> (dispPath == 2'd3 && handlerPc == '0));

  a_r6_hyper_stays: assert property (@(posedge clk) disable iff (!rstN)
    (trapReq && hpstateHpriv && !hpstateRed && curTl < TL_W'(MAX_TL - 1)) |=> dispPath == 2'd1);

  a_r8_addr_sequence: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispPath != 2'd3) |->
      (handlerNpc == handlerPc + ADDR_W'(4) && handlerNnpc == handlerPc + ADDR_W'(8)));

  a_r8_slot_aligned: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |-> handlerPc[4:0] == 5'd0);

  a_r9_tt_recorded: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |=> recTt == $past(trapType));

endmodule

bind trap_dispatch trap_dispatch_chk #(
  .ADDR_W(ADDR_W), .TL_W(TL_W), .MAX_TL(MAX_TL)
) u_chk (
  .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapType(trapType),
  .curTl(curTl), .hpstateRed(hpstateRed), .hpstateHpriv(hpstateHpriv),
  .dispValid(dispValid), .dispPath(dispPath), .recTt(recTt),
  .handlerPc(handlerPc), .handlerNpc(handlerNpc), .handlerNnpc(handlerNnpc)
);

// File: tb/trap_dispatch_test.sv
`timescale 1ns/1ps
module trap_dispatch_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapReq = 1'b0;
  logic [8:0]  trapType = '0;
  logic [2:0]  curTl = '0;
  logic        hpstateRed = 1'b0;
  logic        hpstateHpriv = 1'b0;
  logic        pstatePriv = 1'b0;
  logic [63:0] tba = '0;
  logic [63:0] htba = '0;
  logic        dispValid;
  logic [1:0]  dispPath;
  logic [8:0]  recTt;
  logic [2:0]  vecTl;
  logic [63:0] handlerPc, handlerNpc, handlerNnpc;
  logic [2:0]  porTl;
  logic [1:0]  porGl;
  logic [12:0] porPstate;
  logic [10:0] porHpstate;
  logic [63:0] porTick;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit started = 0;

  always #5 clk = ~clk;

  trap_dispatch uut (
    .clk(clk), .rstN(rstN), .trapReq(trapReq), .trapType(trapType),
    .curTl(curTl), .hpstateRed(hpstateRed), .hpstateHpriv(hpstateHpriv),
    .pstatePriv(pstatePriv), .tba(tba), .htba(htba),
    .dispValid(dispValid), .dispPath(dispPath), .recTt(recTt), .vecTl(vecTl),
    .handlerPc(handlerPc), .handlerNpc(handlerNpc), .handlerNnpc(handlerNnpc),
    .porTl(porTl), .porGl(porGl), .porPstate(porPstate),
    .porHpstate(porHpstate), .porTick(porTick)
  );

  // behavioural reference
  logic        expValid = 0;
  int          expPath = 0;
  int          expTt = 0;
  int          expTl = 0;
  logic [63:0] expPc = 0, expNpc = 0, expNnpc = 0;
  string       expTag = "R1";

  always @(posedge clk) begin
    if (!rstN) begin
      expValid <= 0; expPath <= 0; expTt <= 0; expTl <= 0;
      expPc <= 0; expNpc <= 0; expNnpc <= 0; expTag <= "R1";
    end else begin
      expValid <= trapReq;
      if (trapReq) begin
        int p; int vt; logic [63:0] pc; string tag;
        vt = trapType; pc = 0;
        if (hpstateRed || curTl == 5) begin
          p = 2; vt = 5; tag = "R3";
          pc = 64'hFF_F000_0000 + ((vt * 32) % 256);
        end else if (curTl >= 6) begin
          p = 3; tag = "R4";
        end else if (curTl > 2 && !hpstateHpriv) begin
          p = 1; vt = 2; tag = "R5";
        end else if (hpstateHpriv || trapType >= 384) begin
          p = 1; tag = "R6";
        end else begin
          p = 0; tag = "R7";
        end
        if (p == 1) pc = (htba / 64'd16384) * 64'd16384 + 64'(vt * 32);
        if (p == 0) pc = (tba / 64'd32768) * 64'd32768 +
                         ((curTl + 1 > 1) ? 64'd16384 : 64'd0) + 64'(vt * 32);
        expPath <= p; expTt <= trapType; expTag <= tag;
        expTl   <= (p == 3) ? int'(curTl) : int'(curTl) + 1;
        expPc   <= pc;
        expNpc  <= (p == 3) ? 64'd0 : pc + 4;
        expNnpc <= (p == 3) ? 64'd0 : pc + 8;
      end
    end
  end

  task automatic check64(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      check64("R2", "dispValid", 64'(dispValid), 64'(expValid));
      check64(expTag, "dispPath", 64'(dispPath), 64'(expPath));
      check64("R9", "recTt", 64'(recTt), 64'(expTt));
      check64("R9", "vecTl", 64'(vecTl), 64'(expTl));
      check64(expTag, "handlerPc", handlerPc, expPc);
      check64("R8", "handlerNpc", handlerNpc, expNpc);
      check64("R8", "handlerNnpc", handlerNnpc, expNnpc);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL R2 watchdog expired actual=%0d expected<=5000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic raise(int tt, int tl, bit red, bit hp, bit pv);
    @(negedge clk);
    trapReq = 1; trapType = 9'(tt); curTl = 3'(tl);
    hpstateRed = red; hpstateHpriv = hp; pstatePriv = pv;
  endtask

  task automatic idle();
    @(negedge clk);
    trapReq = 0;
    // scramble the inputs: outputs must not follow them (R2)
    trapType = 9'h1FF; curTl = 3'd7; hpstateRed = 1; hpstateHpriv = 1;
  endtask

  initial begin
    tba  = 64'h0000_1234_5678_FFFF;
    htba = 64'h0000_00AB_CDEF_7FFF;
    repeat (3) @(negedge clk);
    started = 1;   // reset state compared in this window (R1)
    @(negedge clk);
    check64("R1", "porTl", 64'(porTl), 64'd6);
    check64("R1", "porGl", 64'(porGl), 64'd3);
    check64("R1", "porPstate", 64'(porPstate), 64'h014);
    check64("R1", "porHpstate", 64'(porHpstate), 64'h024);
    check64("R1", "porTick", porTick, 64'h8000_0000_0000_0000);
    rstN = 1;
    idle();
    // R7: user at TL0, then TL1 sets bit 14; priv bit has no effect
    raise(9'h24, 0, 0, 0, 0);
    raise(9'h24, 1, 0, 0, 0);
    raise(9'h24, 1, 0, 0, 1);
    raise(383, 0, 0, 0, 1);
    idle(); idle();
    // R6: threshold and hyperprivileged requester
    raise(384, 0, 0, 0, 1);
    raise(9'h10, 2, 0, 1, 0);
    raise(9'h10, 4, 0, 1, 1);
    // R5: guest watchdog above MAX_PTL, boundary at MAX_PTL
    raise(9'h30, 3, 0, 0, 1);
    raise(9'h30, 4, 0, 0, 0);
    raise(9'h30, 2, 0, 0, 1);
    idle();
    // R3: RED bit and TL = MAX_TL-1
    raise(9'h60, 0, 1, 0, 0);
    raise(9'h60, 5, 0, 1, 0);
    raise(9'h60, 6, 1, 0, 0);
    // R4: error at and above MAX_TL
    raise(9'h22, 6, 0, 0, 1);
    raise(9'h22, 7, 0, 1, 0);
    idle(); idle();
    tba  = 64'hFFFF_0000_0000_8000;
    htba = 64'h0000_0000_0000_4000;
    raise(9'h1FF, 1, 0, 0, 0);
    raise(9'h1FF, 0, 0, 1, 0);
    idle(); idle();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule